// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a fully associative translation cache for a processor's memory pipeline. Each slot holds a virtual page number, a physical page number, an address space number, a global bit that lets the slot match in every address space, a valid bit, and an opaque permission field. Permissions are stored and returned to the client, which does its own checking. A client presents a virtual address and the current address space number. In the same cycle it receives a hit flag, the index of the slot that matched, and that slot's fields.

Software-managed refill writes new translations through the insert port. The slot that is written is chosen by a rotating victim pointer. Two maintenance operations are provided. Flush-all empties the whole structure. Flush-by-address removes only the translations for one page that are visible from a given address space. Pages are 8 KB, so the low 13 address bits are the page offset and play no part in matching.

Top module: `asn_tlb`

## Requirements
- R1: A slot matches a request only when it is valid, its stored page number equals the request's page number, and either its global bit is 1 or its stored address space number equals the request's.
- R2: When several slots match, the lowest-index slot is reported. `lk_idx`, `lk_ppn`, `lk_perm` and `lk_global` come from that slot. On a miss, `lk_hit`, `lk_idx`, `lk_ppn`, `lk_perm` and `lk_global` are all 0.
- R3: An insert writes the slot named by the victim pointer, even when that slot already holds a valid translation. The new translation is visible to lookups from the cycle after the clock edge.
- R4: The victim pointer steps by one on every insert and wraps from ENTRIES-1 back to 0. With 16 slots, the 17th insert after the pointer is cleared lands in slot 0.
- R5: Flush-all invalidates every slot and returns the victim pointer to 0. If an insert or a flush-by-address arrives in the same cycle, flush-all takes priority and they have no effect.
- R6: Flush-by-address invalidates every slot that matches the given page number under the R1 rule for the given address space number. Slots with the same page number that belong to another address space and are not global stay valid.
- R7: The page number is address bits [VA_W-1:13]. Bits [12:0] of any address input do not affect matching.
- R8: A synchronous active-high reset invalidates all slots and clears the victim pointer.
- R9: If an insert and a flush-by-address occur in the same cycle, the flush acts on the contents before the edge. The inserted translation is valid afterwards, even when it matches the flushed page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asn | input | ASN_W | Lookup address space number |
| lk_hit | output | 1 | A slot matched the lookup |
| lk_idx | output | log2(ENTRIES) | Index of the reported slot |
| lk_ppn | output | PPN_W | Physical page number of the reported slot |
| lk_perm | output | PERM_W | Permission field of the reported slot |
| lk_global | output | 1 | Global bit of the reported slot |
| ins_en | input | 1 | Insert a translation at the victim slot |
| ins_va | input | VA_W | Virtual address of the new translation |
| ins_asn | input | ASN_W | Address space number of the new translation |
| ins_global | input | 1 | Global bit of the new translation |
| ins_ppn | input | PPN_W | Physical page number of the new translation |
| ins_perm | input | PERM_W | Permission field of the new translation |
| flush_all | input | 1 | Invalidate all slots |
| fa_en | input | 1 | Flush the slots matching one address |
| fa_va | input | VA_W | Address to flush |
| fa_asn | input | ASN_W | Address space number for the flush |

## Verification
The hardest case to reach from the ports is several valid slots sharing one page number but differing in address space or global bit, combined with a flush-by-address or an insert in the same cycle. A short random run over a wide page space almost never produces it. The random stimulus therefore draws page numbers from a set of eight and address space numbers from a set of four, so duplicates and wrap-driven overwrites happen constantly. Directed sequences add the exact cases: duplicates of one page, a flush that spares one address space, an insert colliding with a flush, and flush-all colliding with an insert.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Operation applied at the next clock edge, after priority resolution.
    typedef enum logic [2:0] {
        OP_NONE,
        OP_INSERT,
        OP_FLUSH_ADDR,
        OP_FLUSH_ADDR_INSERT,
        OP_FLUSH_ALL
    } tlb_op_e;

    function automatic tlb_op_e tlb_decode(input logic ins, input logic all, input logic addr);
        if (all)              return OP_FLUSH_ALL;
        else if (ins && addr) return OP_FLUSH_ADDR_INSERT;
        else if (ins)         return OP_INSERT;
        else if (addr)        return OP_FLUSH_ADDR;
        else                  return OP_NONE;
    endfunction

endpackage

// File: rtl/tlb_match.sv
// Per-slot associative compare: valid, tag equal, and global or ASN equal.
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 30,
    parameter int ASN_W   = 8
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0]             glb,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  tags,
    input  logic [ENTRIES-1:0][ASN_W-1:0]  asns,
    input  logic [VPN_W-1:0]               req_vpn,
    input  logic [ASN_W-1:0]               req_asn,
    output logic [ENTRIES-1:0]             hits
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        assign hits[i] = valid[i] && (tags[i] == req_vpn) && (glb[i] || (asns[i] == req_asn));
    end
endmodule

// File: rtl/tlb_first_one.sv
// Lowest-index select: one-hot of the first set bit, its index, and any.
module tlb_first_one #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vec,
    output logic [ENTRIES-1:0] onehot,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);
    always_comb begin
        onehot = '0;
        idx    = '0;
        any    = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vec[i] && !any) begin
                onehot[i] = 1'b1;
                idx       = IDX_W'(i);
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
// Rotating next-victim pointer with wrap at ENTRIES-1.
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr_q
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (clr)
            ptr_d = '0;
        else if (adv)
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int VA_W      = 43,
    parameter int PAGE_BITS = 13,
    parameter int PPN_W     = 28,
    parameter int ASN_W     = 8,
    parameter int PERM_W    = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [VA_W-1:0]              lk_va,
    input  logic [ASN_W-1:0]             lk_asn,
    output logic                         lk_hit,
    output logic [$clog2(ENTRIES)-1:0]   lk_idx,
    output logic [PPN_W-1:0]             lk_ppn,
    output logic [PERM_W-1:0]            lk_perm,
    output logic                         lk_global,
    input  logic                         ins_en,
    input  logic [VA_W-1:0]              ins_va,
    input  logic [ASN_W-1:0]             ins_asn,
    input  logic                         ins_global,
    input  logic [PPN_W-1:0]             ins_ppn,
    input  logic [PERM_W-1:0]            ins_perm,
    input  logic                         flush_all,
    input  logic                         fa_en,
    input  logic [VA_W-1:0]              fa_va,
    input  logic [ASN_W-1:0]             fa_asn
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int VPN_W = VA_W - PAGE_BITS;

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0]             glb;
        logic [ENTRIES-1:0][VPN_W-1:0]  tag;
        logic [ENTRIES-1:0][ASN_W-1:0]  asn;
        logic [ENTRIES-1:0][PPN_W-1:0]  ppn;
        logic [ENTRIES-1:0][PERM_W-1:0] perm;
    } table_t;

    table_t st_d, st_q;

    // Page numbers: the offset bits take no part in matching.
    logic [VPN_W-1:0] lk_vpn, ins_vpn, fa_vpn;
    assign lk_vpn  = lk_va[VA_W-1:PAGE_BITS];
    assign ins_vpn = ins_va[VA_W-1:PAGE_BITS];
    assign fa_vpn  = fa_va[VA_W-1:PAGE_BITS];

    logic unused_offsets;
    assign unused_offsets = ^{lk_va[PAGE_BITS-1:0], ins_va[PAGE_BITS-1:0], fa_va[PAGE_BITS-1:0]};

    tlb_op_e op;
    assign op = tlb_decode(ins_en, flush_all, fa_en);

    logic do_insert;
    assign do_insert = (op == OP_INSERT) || (op == OP_FLUSH_ADDR_INSERT);

    // Victim pointer
    logic [IDX_W-1:0] victim_q;
    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk   (clk),
        .rst   (rst),
        .clr   (op == OP_FLUSH_ALL),
        .adv   (do_insert),
        .ptr_q (victim_q)
    );

    // Lookup path
    logic [ENTRIES-1:0] lk_hits, lk_sel;
    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
        .valid   (st_q.valid),
        .glb     (st_q.glb),
        .tags    (st_q.tag),
        .asns    (st_q.asn),
        .req_vpn (lk_vpn),
        .req_asn (lk_asn),
        .hits    (lk_hits)
    );

    tlb_first_one #(.ENTRIES(ENTRIES)) u_lk_pick (
        .vec    (lk_hits),
        .onehot (lk_sel),
        .idx    (lk_idx),
        .any    (lk_hit)
    );

    always_comb begin
        lk_ppn    = '0;
        lk_perm   = '0;
        lk_global = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_ppn    = lk_ppn    | ({PPN_W{lk_sel[i]}}  & st_q.ppn[i]);
            lk_perm   = lk_perm   | ({PERM_W{lk_sel[i]}} & st_q.perm[i]);
            lk_global = lk_global | (lk_sel[i] & st_q.glb[i]);
        end
    end

    // Flush-by-address path: second compare array on the flush inputs
    logic [ENTRIES-1:0] fa_hits;
    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fa_match (
        .valid   (st_q.valid),
        .glb     (st_q.glb),
        .tags    (st_q.tag),
        .asns    (st_q.asn),
        .req_vpn (fa_vpn),
        .req_asn (fa_asn),
        .hits    (fa_hits)
    );

    // Next-state
    always_comb begin
        st_d = st_q;
        if (op == OP_FLUSH_ALL) begin
            st_d = '0;
        end else begin
            if (op == OP_FLUSH_ADDR || op == OP_FLUSH_ADDR_INSERT)
                st_d.valid = st_q.valid & ~fa_hits;
            if (do_insert) begin
                st_d.valid[victim_q] = 1'b1;
                st_d.glb[victim_q]   = ins_global;
                st_d.tag[victim_q]   = ins_vpn;
                st_d.asn[victim_q]   = ins_asn;
                st_d.ppn[victim_q]   = ins_ppn;
                st_d.perm[victim_q]  = ins_perm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.valid <= '0;
            st_q.glb   <= st_d.glb;
            st_q.tag   <= st_d.tag;
            st_q.asn   <= st_d.asn;
            st_q.ppn   <= st_d.ppn;
            st_q.perm  <= st_d.perm;
        end else begin
            st_q <= st_d;
        end
    end

    logic [ENTRIES-1:0] valid_vec;
    assign valid_vec = st_q.valid;

endmodule

// File: rtl/asn_tlb_chk.sv
module asn_tlb_chk #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               ins_en,
    input logic               flush_all,
    input logic               fa_en,
    input logic               lk_hit,
    input logic [IDX_W-1:0]   lk_idx,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [IDX_W-1:0]   victim
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // R8
    reset_clears_chk: assert property (@(posedge clk) rst |=> (valid_vec == '0 && victim == '0));

    // R5
    flush_all_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (valid_vec == '0 && victim == '0 && !lk_hit));

    // R4
    victim_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !flush_all) |=>
            victim == (($past(victim) == LAST) ? '0 : $past(victim) + 1'b1));

    // R3
    insert_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_en && !flush_all) |=> valid_vec[$past(victim)]);

    // R6
    flush_addr_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
        (fa_en && !ins_en && !flush_all) |=> ((valid_vec & ~$past(valid_vec)) == '0));

    // R2
    hit_slot_valid_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> valid_vec[lk_idx]);

    // R2
    miss_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> lk_idx == '0);
endmodule

bind asn_tlb asn_tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ins_en    (ins_en),
    .flush_all (flush_all),
    .fa_en     (fa_en),
    .lk_hit    (lk_hit),
    .lk_idx    (lk_idx),
    .valid_vec (valid_vec),
    .victim    (victim_q)
);

// File: tb/asn_tlb_bench.sv
`timescale 1ns/1ps
module asn_tlb_bench;
    localparam int N     = 16;
    localparam int VA_W  = 43;
    localparam int PB    = 13;
    localparam int PPN_W = 28;
    localparam int ASN_W = 8;
    localparam int PRM_W = 8;
    localparam int IW    = 4;
    localparam int VPN_W = VA_W - PB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [VA_W-1:0]  lk_va = '0, ins_va = '0, fa_va = '0;
    logic [ASN_W-1:0] lk_asn = '0, ins_asn = '0, fa_asn = '0;
    logic             ins_en = 0, ins_global = 0, flush_all = 0, fa_en = 0;
    logic [PPN_W-1:0] ins_ppn = '0;
    logic [PRM_W-1:0] ins_perm = '0;
    logic             lk_hit, lk_global;
    logic [IW-1:0]    lk_idx;
    logic [PPN_W-1:0] lk_ppn;
    logic [PRM_W-1:0] lk_perm;

    asn_tlb u_asn_tlb (
        .clk(clk), .rst(rst), .lk_va(lk_va), .lk_asn(lk_asn), .lk_hit(lk_hit),
        .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_perm(lk_perm), .lk_global(lk_global),
        .ins_en(ins_en), .ins_va(ins_va), .ins_asn(ins_asn), .ins_global(ins_global),
        .ins_ppn(ins_ppn), .ins_perm(ins_perm), .flush_all(flush_all),
        .fa_en(fa_en), .fa_va(fa_va), .fa_asn(fa_asn)
    );

    // Reference model
    logic             m_v   [N];
    logic             m_g   [N];
    logic [VPN_W-1:0] m_tag [N];
    logic [ASN_W-1:0] m_asn [N];
    logic [PPN_W-1:0] m_ppn [N];
    logic [PRM_W-1:0] m_prm [N];
    int               m_ptr;

    int tests = 0, fails = 0;
    bit done = 0;

    function automatic logic [VA_W-1:0] mk_va(input int vpn, input int off);
        return {VPN_W'(vpn), PB'(off)};
    endfunction

    function automatic bit m_match(input int i, input logic [VA_W-1:0] va, input logic [ASN_W-1:0] a);
        return m_v[i] && m_tag[i] == va[VA_W-1:PB] && (m_g[i] || m_asn[i] == a);
    endfunction

    task automatic m_clear();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_g[i] = 0; m_tag[i] = '0; m_asn[i] = '0; m_ppn[i] = '0; m_prm[i] = '0;
        end
        m_ptr = 0;
    endtask

    task automatic m_update();
        if (rst || flush_all) begin
            m_clear();
        end else begin
            if (fa_en) begin
                bit kill [N];
                for (int i = 0; i < N; i++) kill[i] = m_match(i, fa_va, fa_asn);
                for (int i = 0; i < N; i++) if (kill[i]) m_v[i] = 0;
            end
            if (ins_en) begin
                m_v[m_ptr] = 1; m_g[m_ptr] = ins_global; m_tag[m_ptr] = ins_va[VA_W-1:PB];
                m_asn[m_ptr] = ins_asn; m_ppn[m_ptr] = ins_ppn; m_prm[m_ptr] = ins_perm;
                m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
            end
        end
    endtask

    task automatic check_lookup(input string req);
        bit e_hit = 0; int e_idx = 0; logic [PPN_W-1:0] e_ppn = '0;
        logic [PRM_W-1:0] e_prm = '0; logic e_g = 0;
        for (int i = 0; i < N; i++) begin
            if (!e_hit && m_match(i, lk_va, lk_asn)) begin
                e_hit = 1; e_idx = i; e_ppn = m_ppn[i]; e_prm = m_prm[i]; e_g = m_g[i];
            end
        end
        tests++;
        if (lk_hit !== e_hit || int'(lk_idx) != e_idx || lk_ppn !== e_ppn ||
            lk_perm !== e_prm || lk_global !== e_g) begin
            fails++;
            $display("FAIL %s: hit/idx/ppn/perm/g got %0d/%0d/%h/%h/%0d exp %0d/%0d/%h/%h/%0d",
                     req, lk_hit, lk_idx, lk_ppn, lk_perm, lk_global,
                     e_hit, e_idx, e_ppn, e_prm, e_g);
        end
    endtask

    task automatic expect_eq(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d exp %0d", req, got, exp);
        end
    endtask

    // Called at a negedge with inputs set: check lookup, clock, update model.
    task automatic step(input string req);
        #1;
        check_lookup(req);
        @(posedge clk);
        m_update();
        @(negedge clk);
        ins_en = 0; fa_en = 0; flush_all = 0;
    endtask

    task automatic ins(input int vpn, input int asn, input bit g, input int ppn);
        ins_en = 1; ins_va = mk_va(vpn, vpn * 7); ins_asn = ASN_W'(asn);
        ins_global = g; ins_ppn = PPN_W'(ppn); ins_perm = PRM_W'(ppn ^ 8'h5a);
    endtask

    task automatic look(input int vpn, input int off, input int asn, input string req);
        lk_va = mk_va(vpn, off); lk_asn = ASN_W'(asn);
        step(req);
    endtask

    initial begin
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R8: nothing hits after reset
        look(0, 0, 0, "R8");
        look(5, 3, 1, "R8");

        // R3 R4: fill all slots, then wrap
        for (int i = 0; i < N; i++) begin
            ins(100 + i, 1, 0, 1000 + i);
            step("R3");
        end
        for (int i = 0; i < N; i++) begin
            lk_va = mk_va(100 + i, 0); lk_asn = 1; #1;
            expect_eq("R4 slot order", int'(lk_idx), i);
            step("R4");
        end
        ins(200, 1, 0, 2000); step("R3");
        look(100, 0, 1, "R3 overwritten");
        lk_va = mk_va(200, 0); lk_asn = 1; #1;
        expect_eq("R4 wrap to slot 0", int'(lk_idx), 0);
        expect_eq("R4 wrap hit", int'(lk_hit), 1);
        step("R4");

        // R1: ASN mismatch misses, global hits in any ASN
        look(101, 0, 2, "R1 asn mismatch");
        ins(300, 5, 1, 3000); step("R1");
        lk_va = mk_va(300, 0); lk_asn = 9; #1;
        expect_eq("R1 global hit", int'(lk_hit), 1);
        step("R1");

        // R2: duplicates, lowest index wins
        ins(400, 1, 0, 4000); step("R2");
        ins(400, 1, 0, 4001); step("R2");
        lk_va = mk_va(400, 0); lk_asn = 1; #1;
        expect_eq("R2 lowest index", int'(lk_idx), 2);
        expect_eq("R2 ppn of lowest", int'(lk_ppn), 4000);
        step("R2");

        // R7: offset bits ignored
        lk_va = mk_va(400, 13'h1fff); lk_asn = 1; #1;
        expect_eq("R7 offset ignored", int'(lk_hit), 1);
        step("R7");

        // R6: flush spares other ASN; flush of a global entry
        ins(500, 1, 0, 5000); step("R6");
        ins(500, 2, 0, 5001); step("R6");
        fa_en = 1; fa_va = mk_va(500, 99); fa_asn = 1; step("R6");
        lk_va = mk_va(500, 0); lk_asn = 2; #1;
        expect_eq("R6 other asn kept", int'(lk_idx), 5);
        expect_eq("R6 other asn hit", int'(lk_hit), 1);
        step("R6");
        lk_va = mk_va(500, 0); lk_asn = 1; #1;
        expect_eq("R6 flushed", int'(lk_hit), 0);
        step("R6");
        fa_en = 1; fa_va = mk_va(300, 0); fa_asn = 7; step("R6");
        look(300, 0, 5, "R6 global flushed");

        // R9: insert and flush of same page in one cycle
        ins(600, 3, 0, 6000); fa_en = 1; fa_va = mk_va(600, 0); fa_asn = 3; step("R9");
        lk_va = mk_va(600, 0); lk_asn = 3; #1;
        expect_eq("R9 insert survives", int'(lk_hit), 1);
        step("R9");

        // R5: flush-all beats insert, pointer back to 0
        ins(700, 1, 0, 7000); flush_all = 1; step("R5");
        look(700, 0, 1, "R5 insert dropped");
        look(400, 0, 1, "R5 all gone");
        ins(800, 1, 0, 8000); step("R5");
        lk_va = mk_va(800, 0); lk_asn = 1; #1;
        expect_eq("R5 pointer reset", int'(lk_idx), 0);
        step("R5");

        // Random mix over a small page/ASN space
        void'($urandom(32'd20240611));
        for (int k = 0; k < 3000; k++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 45) begin
                ins(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                    $urandom_range(0, 5) == 0, int'($urandom_range(0, 65535)));
            end else if (r < 55) begin
                fa_en = 1; fa_va = mk_va(int'($urandom_range(0, 7)), int'($urandom_range(0, 8191)));
                fa_asn = ASN_W'($urandom_range(0, 3));
            end else if (r < 60) begin
                ins(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), 0,
                    int'($urandom_range(0, 65535)));
                fa_en = 1; fa_va = mk_va(int'($urandom_range(0, 7)), 0);
                fa_asn = ASN_W'($urandom_range(0, 3));
            end else if (r < 62) begin
                flush_all = 1;
            end
            lk_va = mk_va(int'($urandom_range(0, 7)), int'($urandom_range(0, 8191)));
            lk_asn = ASN_W'($urandom_range(0, 3));
            step("R1 R2 R6 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule